// File: doc/BRIEF.md
# PCI Parity Generator and Checker

This block generates and checks the PAR bit for one PCI agent on a multiplexed address/data bus with byte enables. Each clock it receives a description of the bus phase currently on the wires: whether a phase is present, whether it is an address or a data phase, whether this agent is the master, the transfer direction, and whether the transaction is a special cycle. It also receives the address/data and command/byte-enable lines and the sampled PAR line. From these it works out whether this agent must drive PAR. If so, it presents PAR with its output enable one clock after the phase. If not, it checks the PAR that another agent drove.

A mismatch on a checked phase is classified by phase type and command. An error in a data phase of an ordinary transaction is reported on the active-low PERR#. An error in an address phase, or in the data phase of a special cycle, is reported on the active-low SERR#. An address error also signals that the command must not be acknowledged. When this agent is the target of a write and the write data has bad parity, the transfer still completes toward the master, but the block raises a discard pulse and a sticky flag that stays set until reset.

Top module: `pci_parity_unit`

## Requirements
- R1: In the clock after a phase, `par_out` equals the XOR of all 32 `ad` bits and all 4 `cbe` bits of that phase, so PAR together with those 36 bits has an even number of ones.
- R2: When the agent is master, `par_oe` is 1 in the clock after an address phase and in the clock after a data phase of a write.
- R3: When the agent is target, `par_oe` is 1 in the clock after a data phase of a read.
- R4: `par_oe` is 0 in the clock after any other phase and in the clock after a cycle with no phase: target address phases, target write data, master read data, and idle.
- R5: The agent checks every phase it receives: address phases as target, read data as master, and write data as target. It compares `par_in` in the clock after the phase with the parity of that phase. On a mismatch in a data phase that is not a special cycle, `perr_n` is 0 for exactly one clock, two clocks after the phase.
- R6: On a mismatch in a checked address phase, `serr_n` is 0 and `cmd_nack` is 1, both for exactly one clock, two clocks after the phase.
- R7: On a mismatch in a checked data phase of a special cycle, `serr_n` is 0 for one clock two clocks after the phase, and `perr_n` stays 1.
- R8: On a mismatch in target write data that is not a special cycle, `wr_discard` is 1 in the same clock as the `perr_n` pulse. `wr_perr_sticky` then becomes 1 and remains 1 until reset.
- R9: A phase for which the agent drives PAR is never checked: a wrong `par_in` after it leaves `perr_n`, `serr_n`, `cmd_nack` and `wr_discard` inactive.
- R10: While `rst_n` is 0, after a clock edge `par_oe`=0, `perr_n`=1, `serr_n`=1, `cmd_nack`=0, `wr_discard`=0 and `wr_perr_sticky`=0. A later reset clears a set sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_valid | input | 1 | A bus phase is present this clock |
| phase_is_addr | input | 1 | 1 = address phase, 0 = data phase |
| is_master | input | 1 | 1 = this agent masters the transaction |
| is_write | input | 1 | 1 = write (data flows master to target) |
| special_cycle | input | 1 | Transaction is a special cycle |
| ad | input | 32 | Address/data lines of the phase |
| cbe | input | 4 | Command/byte-enable lines of the phase |
| par_in | input | 1 | PAR as sampled from the bus |
| par_out | output | 1 | Generated PAR for the previous phase |
| par_oe | output | 1 | Drive enable for PAR |
| perr_n | output | 1 | Data parity error, active low |
| serr_n | output | 1 | System error, active low |
| cmd_nack | output | 1 | Command must not be acknowledged |
| wr_discard | output | 1 | Target write data is to be dropped |
| wr_perr_sticky | output | 1 | Set by any discarded write, cleared by reset |

## Verification
The hardest situation to reach from the ports is an error whose report and whose cause sit in different cycles. The bad PAR belongs to the previous phase, while the inputs in the same clock already describe the next phase, in which this agent may be the driver. The stimulus places driven and checked phases back to back. It injects wrong parity only in the clock after the phase it targets. This shows that checking follows the role the agent had in the earlier phase, and that errors raised by consecutive checked phases produce separate one-clock pulses.

// File: rtl/pci_par_pkg.sv
// Package: shared phase context and role decisions for the PCI parity unit.
// Assumes a special-cycle data phase is presented as a write by the master.
package pci_par_pkg;

    typedef struct packed {
        logic valid;
        logic is_addr;
        logic master;
        logic write;
        logic special;
    } phase_ctx_t;

    // True when this agent places PAR on the bus for the given phase.
    function automatic logic agent_drives(phase_ctx_t c);
        logic d;
        if (c.is_addr) d = c.master;
        else           d = (c.master == c.write);
        return c.valid & d;
    endfunction

    // True when this agent is the receiver and must check PAR for the phase.
    function automatic logic agent_checks(phase_ctx_t c);
        logic k;
        if (c.is_addr) k = ~c.master;
        else           k = (c.master != c.write);
        return c.valid & k;
    endfunction

endpackage

// File: rtl/par_tree.sv
// Module: par_tree
// Computes the XOR of W bits through a two-level tree of LEAF-wide slices.
// Assumes W >= 1; unused slice bits are padded with zeros.
module par_tree #(
    parameter int W    = 36,
    parameter int LEAF = 4
) (
    input  logic [W-1:0] din,
    output logic         odd
);
    localparam int NLEAF = (W + LEAF - 1) / LEAF;
    localparam int PADW  = NLEAF * LEAF;

    logic [PADW-1:0]  padded;
    logic [NLEAF-1:0] leaf;

    // Zero-extend the input to a whole number of slices.
    always_comb begin
        padded        = '0;
        padded[W-1:0] = din;
    end

    for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
        assign leaf[i] = ^padded[i*LEAF +: LEAF];
    end

    assign odd = ^leaf;
endmodule

// File: rtl/par_drive.sv
// Module: par_drive
// First pipeline stage: registers the parity and the context of each phase.
// Drives PAR and its enable one clock after the phase when this agent owns PAR.
// Assumes inputs describe the phase present on the bus in the current clock.
module par_drive
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_ctx_t       ctx,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    output logic             par_out,
    output logic             par_oe,
    output phase_ctx_t       s1_ctx,
    output logic             s1_chk
);
    localparam int TOT_W = AD_W + CBE_W;

    logic par_now;

    par_tree #(.W(TOT_W), .LEAF(4)) u_tree (
        .din ({ad, cbe}),
        .odd (par_now)
    );

    // Capture the parity, drive enable, check enable and context of this phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
            s1_chk  <= 1'b0;
            s1_ctx  <= '0;
        end else begin
            par_out <= par_now;
            par_oe  <= agent_drives(ctx);
            s1_chk  <= agent_checks(ctx);
            s1_ctx  <= ctx;
        end
    end

    // The drive enable is never on unless a phase was present one clock earlier.
    assert_oe_follows_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(ctx.valid));

    // Drive and check are mutually exclusive roles for the same phase.
    assert_drive_not_checked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> !s1_chk);
endmodule

// File: rtl/par_check.sv
// Module: par_check
// Second pipeline stage: compares the sampled PAR with the stored parity.
// Classifies a mismatch into PERR#, SERR#, command NACK and write discard.
// Assumes par_in is the PAR sampled in the clock after the phase.
module par_check
    import pci_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_ctx_t s1_ctx,
    input  logic       s1_chk,
    input  logic       s1_par,
    input  logic       par_in,
    output logic       perr_n,
    output logic       serr_n,
    output logic       cmd_nack,
    output logic       wr_discard,
    output logic       wr_perr_sticky
);
    logic mismatch;
    logic data_err;
    logic sys_err;
    logic drop_wr;

    // Decode which report a detected mismatch belongs to.
    always_comb begin
        mismatch = s1_chk & (par_in != s1_par);
        data_err = mismatch & ~s1_ctx.is_addr & ~s1_ctx.special;
        sys_err  = mismatch & (s1_ctx.is_addr | s1_ctx.special);
        drop_wr  = data_err & ~s1_ctx.master & s1_ctx.write;
    end

    // Register the one-clock error reports and the sticky discard flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_n         <= 1'b1;
            serr_n         <= 1'b1;
            cmd_nack       <= 1'b0;
            wr_discard     <= 1'b0;
            wr_perr_sticky <= 1'b0;
        end else begin
            perr_n         <= ~data_err;
            serr_n         <= ~sys_err;
            cmd_nack       <= mismatch & s1_ctx.is_addr;
            wr_discard     <= drop_wr;
            wr_perr_sticky <= wr_perr_sticky | drop_wr;
        end
    end

    assert_discard_with_perr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_discard |-> !perr_n);

    assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_perr_sticky |=> wr_perr_sticky);

    assert_nack_with_serr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_nack |-> !serr_n);

    assert_single_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!perr_n && !serr_n));
endmodule

// File: rtl/pci_parity_unit.sv
// Module: pci_parity_unit (top)
// Generates PAR for the phases this agent owns and checks the rest.
// Assumes phase type, role, direction and special-cycle flag are supplied
// by the bus sequencer in the same clock as the address/data lines.
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_valid,
    input  logic             phase_is_addr,
    input  logic             is_master,
    input  logic             is_write,
    input  logic             special_cycle,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             perr_n,
    output logic             serr_n,
    output logic             cmd_nack,
    output logic             wr_discard,
    output logic             wr_perr_sticky
);
    phase_ctx_t ctx;
    phase_ctx_t s1_ctx;
    logic       s1_chk;

    // Bundle the phase description for the pipeline.
    always_comb begin
        ctx.valid   = phase_valid;
        ctx.is_addr = phase_is_addr;
        ctx.master  = is_master;
        ctx.write   = is_write;
        ctx.special = special_cycle;
    end

    par_drive #(.AD_W(AD_W), .CBE_W(CBE_W)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctx     (ctx),
        .ad      (ad),
        .cbe     (cbe),
        .par_out (par_out),
        .par_oe  (par_oe),
        .s1_ctx  (s1_ctx),
        .s1_chk  (s1_chk)
    );

    par_check u_check (
        .clk            (clk),
        .rst_n          (rst_n),
        .s1_ctx         (s1_ctx),
        .s1_chk         (s1_chk),
        .s1_par         (par_out),
        .par_in         (par_in),
        .perr_n         (perr_n),
        .serr_n         (serr_n),
        .cmd_nack       (cmd_nack),
        .wr_discard     (wr_discard),
        .wr_perr_sticky (wr_perr_sticky)
    );

    assert_par_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (par_out == $past(^{ad, cbe})));

    assert_no_perr_on_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> !$past(par_oe));

    assert_nack_after_target_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_nack |-> ($past(phase_is_addr, 2) && !$past(is_master, 2)));

    assert_master_addr_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && phase_is_addr && is_master) |=> par_oe);
endmodule

// File: tb/tb_pci_parity_unit.sv
// Bench: a behavioural model predicts every output each clock and compares.
module tb_pci_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_valid = 1'b0, phase_is_addr = 1'b0, is_master = 1'b0;
    logic        is_write = 1'b0, special_cycle = 1'b0, par_in = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        par_out, par_oe, perr_n, serr_n, cmd_nack, wr_discard, wr_perr_sticky;

    pci_parity_unit dut (
        .clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase_is_addr(phase_is_addr),
        .is_master(is_master), .is_write(is_write), .special_cycle(special_cycle),
        .ad(ad), .cbe(cbe), .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .perr_n(perr_n), .serr_n(serr_n), .cmd_nack(cmd_nack), .wr_discard(wr_discard),
        .wr_perr_sticky(wr_perr_sticky)
    );

    always #5 clk = ~clk;

    int  vecs = 0, bad = 0;
    bit  done = 1'b0;

    logic e_par = 1'b0, e_oe = 1'b0, e_perr_n = 1'b1, e_serr_n = 1'b1;
    logic e_nack = 1'b0, e_disc = 1'b0, e_sticky = 1'b0;
    logic p_valid = 1'b0, p_addr = 1'b0, p_master = 1'b0, p_write = 1'b0, p_special = 1'b0;
    logic p_par = 1'b0, p_err = 1'b0;

    task automatic chk(input string tag, input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R4 par_oe", par_oe, e_oe);
        if (e_oe) chk("R1 par_out", par_out, e_par);
        chk("R5 perr_n", perr_n, e_perr_n);
        chk("R6 R7 serr_n", serr_n, e_serr_n);
        chk("R6 cmd_nack", cmd_nack, e_nack);
        chk("R8 wr_discard", wr_discard, e_disc);
        chk("R8 wr_perr_sticky", wr_perr_sticky, e_sticky);
    endtask

    // One bus clock: compare, drive a new phase plus PAR for the previous one, predict.
    task automatic step(input logic v, input logic a, input logic m, input logic w,
                        input logic s, input logic [31:0] adv, input logic [3:0] cbv,
                        input logic err);
        logic was_checked, hit;
        @(negedge clk);
        compare_all();
        phase_valid = v; phase_is_addr = a; is_master = m; is_write = w;
        special_cycle = s; ad = adv; cbe = cbv;
        par_in = p_par ^ p_err;
        // Receiver roles: target of an address, master of read data, target of write data.
        if (!p_valid)    was_checked = 1'b0;
        else if (p_addr) was_checked = !p_master;
        else             was_checked = (p_master && !p_write) || (!p_master && p_write);
        hit = was_checked && p_err;
        e_perr_n = !(hit && !p_addr && !p_special);
        e_serr_n = !(hit && (p_addr || p_special));
        e_nack   = hit && p_addr;
        e_disc   = hit && !p_addr && !p_special && !p_master && p_write;
        e_sticky = e_sticky || e_disc;
        if (!v)     e_oe = 1'b0;
        else if (a) e_oe = m;
        else        e_oe = (m && w) || (!m && !w);
        e_par = ^{adv, cbv};
        p_valid = v; p_addr = a; p_master = m; p_write = w; p_special = s;
        p_par = ^{adv, cbv}; p_err = err;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phase_valid = 1'b0; phase_is_addr = 1'b0; is_master = 1'b0; is_write = 1'b0;
        special_cycle = 1'b0; par_in = 1'b0; ad = '0; cbe = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 par_oe", par_oe, 1'b0);
        chk("R10 perr_n", perr_n, 1'b1);
        chk("R10 serr_n", serr_n, 1'b1);
        chk("R10 cmd_nack", cmd_nack, 1'b0);
        chk("R10 wr_discard", wr_discard, 1'b0);
        chk("R10 wr_perr_sticky", wr_perr_sticky, 1'b0);
        e_oe = 1'b0; e_perr_n = 1'b1; e_serr_n = 1'b1; e_nack = 1'b0;
        e_disc = 1'b0; e_sticky = 1'b0;
        p_valid = 1'b0; p_par = 1'b0; p_err = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(300000 * 10);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R9: master address phase with wrong PAR echoed: driven, never checked.
        step(1, 1, 1, 1, 0, 32'hDEAD_BEEF, 4'h7, 1);
        // R2 R9: master write data, wrong PAR ignored.
        step(1, 0, 1, 1, 0, 32'h0000_0001, 4'h0, 1);
        // R4 R5: master read data with bad PAR gives PERR#.
        step(1, 0, 1, 0, 0, 32'hFFFF_FFFF, 4'hF, 1);
        // R4 R6: target address with bad PAR gives SERR# and NACK.
        step(1, 1, 0, 1, 0, 32'h1234_5678, 4'h3, 1);
        // R4 R8: target write data with bad PAR gives PERR#, discard, sticky.
        step(1, 0, 0, 1, 0, 32'hA5A5_0F0F, 4'hC, 1);
        // R3: target read data drives PAR, wrong echo ignored.
        step(1, 0, 0, 0, 0, 32'h8000_0000, 4'h1, 1);
        // R7: special-cycle data received with bad PAR gives SERR# only.
        step(1, 0, 0, 1, 1, 32'h0F0F_0F0F, 4'h5, 1);
        // R8: good target write; sticky stays set.
        step(1, 0, 0, 1, 0, 32'h5555_AAAA, 4'h9, 0);
        // Back-to-back checked errors give separate pulses (R5 R6).
        step(1, 1, 0, 0, 0, 32'h0000_00FF, 4'h2, 1);
        step(1, 0, 0, 1, 0, 32'h0000_0F00, 4'hE, 1);
        step(1, 0, 1, 0, 0, 32'h00F0_0000, 4'h4, 1);
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[3], r[4], r[5] & ~r[2], $urandom, r[11:8],
                 (r[7:6] == 2'b00));
        end
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
        // R10: a second reset clears the sticky flag.
        do_reset();
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule